// File: doc/BRIEF.md
# Glass-break frame classifier

At the end of an acoustic analysis frame, this block decides whether the frame sounded like breaking glass. A start pulse latches six frame results:

- the running integral of the whole band;
- the running integral of the high-pass band;
- the overflow count of each of those two integrals;
- the number of signal peaks;
- the number of zero crossings.

The block brings the two integrals to a common binary exponent and divides the total integral by the high-pass integral, one quotient bit per clock. It then estimates the fractional part of the quotient in quarter steps.

Three rules decide the result: a ratio window, a peak-count window and a zero-crossing window. The block reports a fail flag for each rule and a one-cycle detect pulse when all three pass. A busy/done pair tells the surrounding logic when the result is ready. Computing the features, driving any alarm and managing power are left to neighbouring blocks.

Top module: `gbreak_frame_classifier`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, busy, done, detect and the three fail flags are all 0.
- R2: A start seen while busy is low latches all six frame inputs and raises busy at the next cycle. A start seen while busy is high is ignored, and a later change of the inputs does not alter the result being computed.
- R3: Busy stays high for N+20 cycles on the normal path, where N is the total overflow count. It stays high for 1 cycle when the ratio rule fails early (R4), and for N+3 cycles when the divisor is zero (R6). In the cycle after that, done is high for exactly one cycle and busy is low.
- R4: If the total overflow count is smaller than the high-pass overflow count, the ratio rule fails without any division.
- R5: Otherwise the block performs N scaling steps. In each step the total integral shifts right by one with 1 entering its MSB. In the same step the high-pass integral shifts right by one, with 1 entering its MSB while high-pass overflows remain to be consumed and 0 once they are used up.
- R6: After scaling, if the MSB of the high-pass value is 1, both values shift right once more with 0 entering. If the high-pass value is then zero, the ratio rule fails.
- R7: The quotient Q and remainder of total / high-pass come from a 16-step restoring division. The ratio rule passes only when 1 ≤ Q ≤ 6.
- R8: The fraction count F is the number of times the divisor shifted right by two fits into the remainder, limited to 3. It is 3 when that shifted divisor is zero. When Q equals 1, the ratio rule also needs F = 3.
- R9: The peak rule fails unless 160 ≤ peaks < 320, with the count taken as unsigned.
- R10: The zero-crossing rule fails unless 95 ≤ zeros < 300, with the count taken as unsigned.
- R11: The fail flags update only in the done cycle and hold until the next done. Detect is high only in a done cycle, and then exactly when none of the three flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start of classification, one cycle |
| tot_int | input | 16 | Whole-band integral |
| hp_int | input | 16 | High-pass integral |
| tot_ovf | input | 16 | Overflow count of the whole-band integral |
| hp_ovf | input | 16 | Overflow count of the high-pass integral |
| peak_cnt | input | 16 | Peak count of the frame |
| zero_cnt | input | 16 | Zero-crossing count of the frame |
| busy | output | 1 | Classification in progress |
| done | output | 1 | One-cycle result strobe |
| detect | output | 1 | Glass break recognised, pulse with done |
| ratio_fail | output | 1 | Ratio rule failed (held) |
| peak_fail | output | 1 | Peak rule failed (held) |
| zero_fail | output | 1 | Zero-crossing rule failed (held) |

## Verification
Plain integrals without overflow test the quotient window: quotients of 0, 3, 6 and 7 show where the window edges lie, and quotients of exactly 1 with remainders above and below three quarters of the divisor separate the two outcomes of the fraction rule. Overflow pairs check the other ratio paths. A pair with more high-pass than total overflows must take the one-cycle early exit. A pair with more total than high-pass overflows exercises the switch from 1 to 0 insertion. A large count shifts both values out entirely. A divisor with its MSB set and a zero divisor test the alignment step and the short zero-divisor path. Peak and zero-crossing counts placed one below and exactly on each window edge test the inclusive lower bounds and exclusive upper bounds. A second start issued during a run, with the inputs changed, must leave both timing and result unchanged.

// File: rtl/gbreak_frame_classifier.sv
module gbreak_frame_classifier #(
  parameter int W        = 16,
  parameter int CW       = 16,
  parameter int PEAK_MIN = 160,
  parameter int PEAK_MAX = 320,
  parameter int ZERO_MIN = 95,
  parameter int ZERO_MAX = 300,
  parameter int Q_MIN    = 1,
  parameter int Q_MAX    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  tot_int,
  input  logic [W-1:0]  hp_int,
  input  logic [CW-1:0] tot_ovf,
  input  logic [CW-1:0] hp_ovf,
  input  logic [CW-1:0] peak_cnt,
  input  logic [CW-1:0] zero_cnt,
  output logic          busy,
  output logic          done,
  output logic          detect,
  output logic          ratio_fail,
  output logic          peak_fail,
  output logic          zero_fail
);
  localparam int IT_W = $clog2(W);
  localparam logic [IT_W-1:0] IT_LAST = IT_W'(W - 1);
  localparam logic [CW-1:0]   PK_LO = CW'(PEAK_MIN);
  localparam logic [CW-1:0]   PK_HI = CW'(PEAK_MAX);
  localparam logic [CW-1:0]   ZC_LO = CW'(ZERO_MIN);
  localparam logic [CW-1:0]   ZC_HI = CW'(ZERO_MAX);
  localparam logic [W-1:0]    QLO   = W'(Q_MIN);
  localparam logic [W-1:0]    QHI   = W'(Q_MAX);
  localparam logic [W-1:0]    QONE  = W'(1);

  typedef enum logic [2:0] {S_IDLE, S_SCALE, S_ALIGN, S_DIV, S_FRAC, S_FIN} st_t;

  st_t            st;
  logic [W-1:0]   num, den, quo, rem;
  logic [CW-1:0]  t_left, h_left;
  logic [IT_W-1:0] it;
  logic           r_bad, pk_bad, zc_bad;

  logic [W-1:0]   den_al, num_al, a_sh;
  logic [W:0]     trial;
  logic [W+1:0]   rem_x, d4_x;
  logic [1:0]     frac;
  logic           ratio_ok;

  assign busy   = (st != S_IDLE);
  assign den_al = den[W-1] ? {1'b0, den[W-1:1]} : den;
  assign num_al = den[W-1] ? {1'b0, num[W-1:1]} : num;
  assign a_sh   = {rem[W-2:0], quo[W-1]};
  assign trial  = {1'b0, a_sh} - {1'b0, den};
  assign rem_x  = {2'b00, rem};
  assign d4_x   = {4'b0000, den[W-1:2]};

  always_comb begin
    if (rem_x >= d4_x + d4_x + d4_x) frac = 2'd3;
    else if (rem_x >= d4_x + d4_x)   frac = 2'd2;
    else if (rem_x >= d4_x)          frac = 2'd1;
    else                             frac = 2'd0;
  end

  assign ratio_ok = (quo >= QLO) && (quo <= QHI) && ((quo != QONE) || (frac == 2'd3));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      num <= '0; den <= '0; quo <= '0; rem <= '0;
      t_left <= '0; h_left <= '0; it <= '0;
      r_bad <= 1'b0; pk_bad <= 1'b0; zc_bad <= 1'b0;
      done <= 1'b0; detect <= 1'b0;
      ratio_fail <= 1'b0; peak_fail <= 1'b0; zero_fail <= 1'b0;
    end else begin
      done   <= 1'b0;
      detect <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          num    <= tot_int;
          den    <= hp_int;
          t_left <= tot_ovf;
          h_left <= hp_ovf;
          pk_bad <= !((peak_cnt >= PK_LO) && (peak_cnt < PK_HI));
          zc_bad <= !((zero_cnt >= ZC_LO) && (zero_cnt < ZC_HI));
          r_bad  <= (tot_ovf < hp_ovf);
          st     <= (tot_ovf < hp_ovf) ? S_FIN : S_SCALE;
        end
        S_SCALE: begin
          if (t_left == '0) st <= S_ALIGN;
          else begin
            num    <= {1'b1, num[W-1:1]};
            den    <= {(h_left != '0), den[W-1:1]};
            if (h_left != '0) h_left <= h_left - 1'b1;
            t_left <= t_left - 1'b1;
          end
        end
        S_ALIGN: begin
          num <= num_al;
          den <= den_al;
          quo <= num_al;
          rem <= '0;
          it  <= '0;
          if (den_al == '0) begin
            r_bad <= 1'b1;
            st    <= S_FIN;
          end else st <= S_DIV;
        end
        S_DIV: begin
          quo <= {quo[W-2:0], ~trial[W]};
          rem <= trial[W] ? a_sh : trial[W-1:0];
          it  <= it + 1'b1;
          if (it == IT_LAST) st <= S_FRAC;
        end
        S_FRAC: begin
          r_bad <= !ratio_ok;
          st    <= S_FIN;
        end
        S_FIN: begin
          st         <= S_IDLE;
          done       <= 1'b1;
          ratio_fail <= r_bad;
          peak_fail  <= pk_bad;
          zero_fail  <= zc_bad;
          detect     <= !(r_bad || pk_bad || zc_bad);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gbreak_frame_classifier_chk.sv
module gbreak_frame_classifier_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic detect,
  input logic ratio_fail,
  input logic peak_fail,
  input logic zero_fail
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  // R11
  detect_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> (done && !ratio_fail && !peak_fail && !zero_fail));
  // R11
  detect_given_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ratio_fail && !peak_fail && !zero_fail) |-> detect);
  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({ratio_fail, peak_fail, zero_fail}));
endmodule

bind gbreak_frame_classifier gbreak_frame_classifier_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .detect(detect), .ratio_fail(ratio_fail), .peak_fail(peak_fail), .zero_fail(zero_fail)
);

// File: tb/gbreak_frame_classifier_tb_top.sv
module gbreak_frame_classifier_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] tot_int = '0, hp_int = '0, tot_ovf = '0, hp_ovf = '0, peak_cnt = '0, zero_cnt = '0;
  logic busy, done, detect, ratio_fail, peak_fail, zero_fail;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  gbreak_frame_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tot_int(tot_int), .hp_int(hp_int),
    .tot_ovf(tot_ovf), .hp_ovf(hp_ovf), .peak_cnt(peak_cnt), .zero_cnt(zero_cnt),
    .busy(busy), .done(done), .detect(detect),
    .ratio_fail(ratio_fail), .peak_fail(peak_fail), .zero_fail(zero_fail)
  );

  // reference model state
  int    m_left = 0;
  logic  m_done = 0, m_det = 0, m_rf = 0, m_pf = 0, m_zf = 0;
  logic  p_rf, p_pf, p_zf;
  string cur_tag = "R1";

  function automatic void classify(input int tot, input int hp, input int tov, input int hov,
                                   input int pk, input int zc,
                                   output logic rf, output logic pf, output logic zf, output int lat);
    int t, h, hr, q, r, d4, fr;
    pf = !(pk >= 160 && pk < 320);
    zf = !(zc >= 95 && zc < 300);
    if (tov < hov) begin rf = 1'b1; lat = 1; return; end
    t = tot; h = hp; hr = hov;
    for (int i = 0; i < tov; i++) begin
      t = (t >> 1) | 32'h8000;
      h = (h >> 1) | ((hr > 0) ? 32'h8000 : 0);
      if (hr > 0) hr--;
    end
    if ((h & 32'h8000) != 0) begin h = h >> 1; t = t >> 1; end
    if (h == 0) begin rf = 1'b1; lat = tov + 3; return; end
    q = t / h; r = t % h; d4 = h >> 2;
    fr = (d4 == 0) ? 3 : ((r / d4 > 3) ? 3 : r / d4);
    rf = !(q >= 1 && q <= 6 && (q != 1 || fr == 3));
    lat = tov + 20;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_left = 0; m_done = 0; m_det = 0; m_rf = 0; m_pf = 0; m_zf = 0;
    end else begin
      m_done = 0; m_det = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_done = 1; m_rf = p_rf; m_pf = p_pf; m_zf = p_zf;
          m_det = !(p_rf || p_pf || p_zf);
        end
      end else if (start) begin
        int lat;
        classify(tot_int, hp_int, tot_ovf, hp_ovf, peak_cnt, zero_cnt, p_rf, p_pf, p_zf, lat);
        m_left = lat;
      end
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", cur_tag, what, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("busy R3", busy, m_left > 0);
      cmp("done R3", done, m_done);
      cmp("detect R11", detect, m_det);
      cmp("ratio_fail", ratio_fail, m_rf);
      cmp("peak_fail R9", peak_fail, m_pf);
      cmp("zero_fail R10", zero_fail, m_zf);
    end
  end

  task automatic run_case(input string tag, input int tot, input int hp, input int tov, input int hov,
                          input int pk, input int zc, input bit poke);
    @(negedge clk);
    cur_tag = tag;
    tot_int = 16'(tot); hp_int = 16'(hp); tot_ovf = 16'(tov); hp_ovf = 16'(hov);
    peak_cnt = 16'(pk); zero_cnt = 16'(zc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      // R2: second start while busy, with different inputs
      tot_int = 16'h0010; hp_int = 16'h0001; peak_cnt = 16'd5; zero_cnt = 16'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    checks++;
    if ({busy, done, detect, ratio_fail, peak_fail, zero_fail} !== 6'b0) begin
      errors++;
      $display("FAIL R1 outputs in reset: actual %b expected 000000",
               {busy, done, detect, ratio_fail, peak_fail, zero_fail});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({busy, done, detect, ratio_fail, peak_fail, zero_fail} !== 6'b0) begin
      errors++;
      $display("FAIL R1 outputs after reset: actual %b expected 000000",
               {busy, done, detect, ratio_fail, peak_fail, zero_fail});
    end

    run_case("R7 R11 q3 pass",      1000,  300, 0, 0, 200, 150, 0);
    run_case("R7 q6 pass",          1300,  200, 0, 0, 200, 150, 0);
    run_case("R7 q7 fail",          1400,  200, 0, 0, 200, 150, 0);
    run_case("R7 q0 fail",           100,  200, 0, 0, 200, 150, 0);
    run_case("R8 q1 frac3 pass",     390,  200, 0, 0, 200, 150, 0);
    run_case("R8 q1 frac2 fail",     340,  200, 0, 0, 200, 150, 0);
    run_case("R8 tiny divisor",        5,    3, 0, 0, 200, 150, 0);
    run_case("R4 early fail",       1000,  300, 1, 2, 200, 150, 0);
    run_case("R5 partial ones",  'h1000, 'h0400, 2, 1, 200, 150, 0);
    run_case("R5 equal counts",  'h0300, 'h0100, 3, 3, 200, 150, 0);
    run_case("R5 long scale",    'h1234, 'h0042, 20, 5, 200, 150, 0);
    run_case("R6 msb align",     'hF000, 'h9000, 0, 0, 200, 150, 0);
    run_case("R6 zero divisor",     1000,    0, 0, 0, 200, 150, 0);
    run_case("R6 zero after scale", 1000,    0, 4, 0, 200, 150, 0);
    run_case("R9 peaks 159",        1000,  300, 0, 0, 159, 150, 0);
    run_case("R9 peaks 160",        1000,  300, 0, 0, 160, 150, 0);
    run_case("R9 peaks 319",        1000,  300, 0, 0, 319, 150, 0);
    run_case("R9 peaks 320",        1000,  300, 0, 0, 320, 150, 0);
    run_case("R10 zeros 94",        1000,  300, 0, 0, 200,  94, 0);
    run_case("R10 zeros 95",        1000,  300, 0, 0, 200,  95, 0);
    run_case("R10 zeros 299",       1000,  300, 0, 0, 200, 299, 0);
    run_case("R10 zeros 300",       1000,  300, 0, 0, 200, 300, 0);
    run_case("R2 start while busy", 1000,  300, 2, 1, 200, 150, 1);
    run_case("R11 all fail",         100,    0, 0, 0,  10,  10, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule